// File: doc/BRIEF.md
# ADC conversion cycle sequencer

This block sequences the digital side of a low-power oversampling converter. It runs a fixed three-phase loop. First comes a timed conversion with the converter powered. Then a low-power hold phase keeps the finished result. Last, a serial read phase sends that result to the host, one bit per read strobe, most significant bit first. The conversion phase cannot be interrupted by the host. The hold phase waits until the host opens a read. A new conversion begins as soon as the word has been fully read, or at once if the host aborts the read part way.

The conversion length comes from one of two cycle counts, selected by `rate_fast`. The input is looked at only in the first cycle of each conversion. When a conversion ends, the converter enable always drops. The reference enable also drops when the host has asked for full power-down. A supply-fault input acts as a power-on reset: it clears the block asynchronously and restarts it in the conversion phase.

Top module: `adc_cycle_seq`

## Requirements
- R1: After `rst_n` is released, outputs first show the reset state: `busy`=1, `converter_enable`=1, `reference_enable`=1, `bit_count`=0, `data_out`=0. Reset release passes through a two-stage synchronizer before the first conversion cycle.
- R2: A conversion lasts `CONV_SLOW` clock cycles when `rate_fast` is 0 and `CONV_FAST` cycles when it is 1. `rate_fast` is sampled in the first conversion cycle, so a change made later applies only to the next conversion.
- R3: While `busy` is 1, `rd_start`, `rd_strobe` and `rd_stop` have no effect: the conversion length is unchanged and `bit_count` stays 0.
- R4: During a conversion, `converter_enable` and `reference_enable` are both 1. After the conversion, `converter_enable` is 0 and `busy` is 0. `reference_enable` is 0 only if `sleep_req` was 1 in the last conversion cycle.
- R5: The result is taken from `sample_data` in the last conversion cycle and held. Later changes to `sample_data` do not alter the word that is read out.
- R6: In the hold phase, `rd_strobe` and `rd_stop` are ignored. `rd_start` opens the read, and in the next cycle `data_out` shows result bit 15. Each `rd_strobe` then moves `data_out` to the next lower bit and raises `bit_count` by one.
- R7: The 16th `rd_strobe` of a read starts a new conversion in the next cycle, with `busy`=1 and `bit_count`=0.
- R8: `rd_stop` during a read aborts it. A new conversion starts in the next cycle with `bit_count`=0.
- R9: `supply_fault`=1 forces the R1 reset state at once, without waiting for a clock. After it drops, a full conversion runs following the two synchronizer cycles.
- R10: `data_out` is 0 whenever no read is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_fault | input | 1 | Supply-low fault, acts as power-on reset |
| rate_fast | input | 1 | 1 selects the short conversion |
| sleep_req | input | 1 | Host request to also power down the reference |
| sample_data | input | 16 | Result word from the decimation filter |
| rd_start | input | 1 | Addressed read start from the host interface |
| rd_strobe | input | 1 | One-cycle read clock strobe, advances one bit |
| rd_stop | input | 1 | Stop condition that aborts the read |
| converter_enable | output | 1 | Converter power enable |
| reference_enable | output | 1 | Reference power enable |
| busy | output | 1 | High while a conversion runs (result not ready) |
| data_out | output | 1 | Serial result bit |
| bit_count | output | 4 | Number of result bits already sent |

## Verification
The checker watches properties that must hold on every cycle. The two enables must stay high while `busy` is high. A powered reference may never sit beside a sleeping converter the wrong way round. `bit_count` may only step by one or return to zero, and must hold still when no strobe or stop arrived. Every `busy` pulse, counted in the checker, must last exactly one of the two configured lengths. Some behaviour only the bench scenarios can show. They show which length goes with which `rate_fast` value, and that a mid-conversion rate change is deferred. They show that the held word survives later changes to `sample_data` and is sent bit for bit in the right order. They also cover aborted reads and the timing of a supply fault.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_CONV = 2'd0,
    ST_NAP  = 2'd1,
    ST_DIO  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // assertion is asynchronous, release walks through STAGES flops
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/adc_seq_conv_timer.sv
module adc_seq_conv_timer #(
  parameter int unsigned CONV_SLOW = 960_000,
  parameter int unsigned CONV_FAST = 240_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate_fast,
  output logic done
);

  localparam int unsigned CW = $clog2(CONV_SLOW + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] lim;
  logic          fast_q;
  logic          first;
  logic          fast_eff;
  logic          fast_en;

  // the rate is taken in the first cycle only, then held
  always_comb begin
    first    = (cnt_q == '0);
    fast_en  = run && first;
    fast_eff = fast_en ? rate_fast : fast_q;
    lim      = fast_eff ? CW'(CONV_FAST - 1) : CW'(CONV_SLOW - 1);
    done     = run && (cnt_q == lim);
    if (!run || done) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      if (fast_en) begin
        fast_q <= rate_fast;
      end
    end
  end

endmodule

// File: rtl/adc_seq_readout.sv
module adc_seq_readout #(
  parameter int unsigned RES_W = 16,
  localparam int unsigned BCW = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [RES_W-1:0] sample,
  input  logic             dio_next,
  input  logic             shift,
  input  logic             clear,
  output logic             last,
  output logic [BCW-1:0]   bit_count,
  output logic             data_out
);

  logic [RES_W-1:0] hold_q;
  logic [BCW-1:0]   bcnt_q;
  logic [BCW-1:0]   bcnt_n;
  logic [BCW-1:0]   idx;
  logic             dout_q;
  logic             dout_n;

  // result word is never shifted: a bit index walks down it instead
  always_comb begin
    if (clear) begin
      bcnt_n = '0;
    end else if (shift) begin
      bcnt_n = bcnt_q + 1'b1;
    end else begin
      bcnt_n = bcnt_q;
    end
    last   = shift && (bcnt_q == BCW'(RES_W - 1));
    idx    = BCW'(RES_W - 1) - bcnt_n;
    dout_n = dio_next && hold_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (capture) begin
      hold_q <= sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      dout_q <= 1'b0;
    end else begin
      bcnt_q <= bcnt_n;
      dout_q <= dout_n;
    end
  end

  assign bit_count = bcnt_q;
  assign data_out  = dout_q;

endmodule

// File: rtl/adc_cycle_seq.sv
module adc_cycle_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CONV_SLOW  = 960_000,
  parameter int unsigned CONV_FAST  = 240_000,
  parameter int unsigned RES_W      = 16,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned BCW = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_fault,
  input  logic             rate_fast,
  input  logic             sleep_req,
  input  logic [RES_W-1:0] sample_data,
  input  logic             rd_start,
  input  logic             rd_strobe,
  input  logic             rd_stop,
  output logic             converter_enable,
  output logic             reference_enable,
  output logic             busy,
  output logic             data_out,
  output logic [BCW-1:0]   bit_count
);

  logic       arst_n;
  logic       rst_q_n;
  seq_state_e state_q;
  seq_state_e state_n;
  logic       tmr_run;
  logic       tmr_done;
  logic       last_bit;
  logic       shift_en;
  logic       clr_cnt;
  logic       dio_next;
  logic       slp_q;
  logic       slp_n;
  logic       conv_en_q;
  logic       conv_en_n;
  logic       ref_en_q;
  logic       ref_en_n;
  logic       busy_q;

  // supply fault behaves exactly like a power-on reset
  assign arst_n = rst_n & ~supply_fault;

  adc_seq_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst (
    .clk       (clk),
    .arst_n    (arst_n),
    .rst_sync_n(rst_q_n)
  );

  assign tmr_run = (state_q == ST_CONV);

  adc_seq_conv_timer #(
    .CONV_SLOW(CONV_SLOW),
    .CONV_FAST(CONV_FAST)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .run      (tmr_run),
    .rate_fast(rate_fast),
    .done     (tmr_done)
  );

  // next state: conversion runs to completion, host acts only afterwards
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_CONV: if (tmr_done) state_n = ST_NAP;
      ST_NAP:  if (rd_start) state_n = ST_DIO;
      ST_DIO:  if (rd_stop || last_bit) state_n = ST_CONV;
      default: state_n = ST_CONV;
    endcase
  end

  always_comb begin
    shift_en  = (state_q == ST_DIO) && rd_strobe && !rd_stop;
    clr_cnt   = (state_n == ST_CONV);
    dio_next  = (state_n == ST_DIO);
    slp_n     = tmr_done ? sleep_req : slp_q;
    conv_en_n = (state_n == ST_CONV);
    ref_en_n  = conv_en_n || !slp_n;
  end

  adc_seq_readout #(
    .RES_W(RES_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .capture  (tmr_done),
    .sample   (sample_data),
    .dio_next (dio_next),
    .shift    (shift_en),
    .clear    (clr_cnt),
    .last     (last_bit),
    .bit_count(bit_count),
    .data_out (data_out)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_CONV;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      slp_q     <= 1'b0;
      conv_en_q <= 1'b1;
      ref_en_q  <= 1'b1;
      busy_q    <= 1'b1;
    end else begin
      slp_q     <= slp_n;
      conv_en_q <= conv_en_n;
      ref_en_q  <= ref_en_n;
      busy_q    <= conv_en_n;
    end
  end

  assign converter_enable = conv_en_q;
  assign reference_enable = ref_en_q;
  assign busy             = busy_q;

endmodule

// File: rtl/adc_cycle_seq_chk.sv
module adc_cycle_seq_chk #(
  parameter int unsigned CONV_SLOW = 960_000,
  parameter int unsigned CONV_FAST = 240_000,
  parameter int unsigned BCW       = 4
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic           busy,
  input logic           converter_enable,
  input logic           reference_enable,
  input logic [BCW-1:0] bit_count,
  input logic           rd_strobe,
  input logic           rd_stop
);

  localparam int unsigned LW = $clog2(CONV_SLOW + 2);

  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      run_len <= '0;
    end else if (busy) begin
      run_len <= run_len + 1'b1;
    end else begin
      run_len <= '0;
    end
  end

  AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy |-> (converter_enable && reference_enable)); // R4

  AST_REF_NOT_ALONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !reference_enable |-> !converter_enable); // R4

  AST_CONV_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy |-> (bit_count == '0)); // R3

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(busy) |-> ((run_len == LW'(CONV_FAST)) || (run_len == LW'(CONV_SLOW)))); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bit_count != $past(bit_count)) |->
      ((bit_count == $past(bit_count) + 1'b1) || (bit_count == '0))); // R6

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && $past(!busy) && !$past(rd_strobe) && !$past(rd_stop)) |->
      $stable(bit_count)); // R6

endmodule

bind adc_cycle_seq adc_cycle_seq_chk #(
  .CONV_SLOW(CONV_SLOW),
  .CONV_FAST(CONV_FAST),
  .BCW      (BCW)
) u_chk (
  .clk             (clk),
  .rst_q_n         (rst_q_n),
  .busy            (busy),
  .converter_enable(converter_enable),
  .reference_enable(reference_enable),
  .bit_count       (bit_count),
  .rd_strobe       (rd_strobe),
  .rd_stop         (rd_stop)
);

// File: tb/sim_adc_cycle_seq.sv
`timescale 1ns/1ps
module sim_adc_cycle_seq;

  localparam int unsigned SLOW = 20;
  localparam int unsigned FAST = 8;

  logic        clk;
  logic        rst_n;
  logic        supply_fault;
  logic        rate_fast;
  logic        sleep_req;
  logic [15:0] sample_data;
  logic        rd_start;
  logic        rd_strobe;
  logic        rd_stop;
  logic        converter_enable;
  logic        reference_enable;
  logic        busy;
  logic        data_out;
  logic [3:0]  bit_count;

  int   n_chk;
  int   n_fail;
  bit   mon_en;
  bit   finished;
  logic [4:0] exp_q[$];

  adc_cycle_seq #(
    .CONV_SLOW(SLOW),
    .CONV_FAST(FAST)
  ) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .supply_fault    (supply_fault),
    .rate_fast       (rate_fast),
    .sleep_req       (sleep_req),
    .sample_data     (sample_data),
    .rd_start        (rd_start),
    .rd_strobe       (rd_strobe),
    .rd_stop         (rd_stop),
    .converter_enable(converter_enable),
    .reference_enable(reference_enable),
    .busy            (busy),
    .data_out        (data_out),
    .bit_count       (bit_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_idle(input string req, input bit ref_exp);
    chk({req, " busy"}, busy, 0);
    chk({req, " converter_enable"}, converter_enable, 0);
    chk({req, " reference_enable"}, reference_enable, ref_exp);
    chk({req, " data_out (R10)"}, data_out, 0);
  endtask

  task automatic chk_reset(input string req);
    chk({req, " busy"}, busy, 1);
    chk({req, " converter_enable"}, converter_enable, 1);
    chk({req, " reference_enable"}, reference_enable, 1);
    chk({req, " bit_count"}, bit_count, 0);
    chk({req, " data_out"}, data_out, 0);
  endtask

  // scoreboard monitor: one expected {count, bit} item per enabled negedge
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_q.size() == 0) begin
        chk("R6 scoreboard underflow", 1, 0);
      end else begin
        logic [4:0] it;
        it = exp_q.pop_front();
        chk("R6 data_out bit", data_out, it[0]);
        chk("R6 bit_count", bit_count, it[4:1]);
      end
    end
  end

  // driver: open a read, push the expected bits, strobe nb times
  task automatic read_bits(input logic [15:0] w, input int nb);
    rd_start = 1'b1;
    go();
    rd_start = 1'b0;
    for (int k = 0; k < nb; k++) begin
      exp_q.push_back({4'(k), w[15-k]});
      rd_strobe = 1'b1;
      mon_en    = 1'b1;
      go();
    end
    rd_strobe = 1'b0;
    mon_en    = 1'b0;
  endtask

  // mode 0 plain, 1 flip rate_fast mid-way, 2 toggle read inputs (R3)
  task automatic measure(input int mode, input string req, output int n);
    n = 0;
    @(negedge clk);
    chk({req, " busy at start"}, busy, 1);
    chk({req, " bit_count at start"}, bit_count, 0);
    while (busy && n < 1000) begin
      n++;
      chk("R4 enables during conversion", converter_enable & reference_enable, 1);
      if (mode == 1 && n == 3) rate_fast = ~rate_fast;
      if (mode == 2) begin
        rd_start  = n[0];
        rd_strobe = ~n[0];
        rd_stop   = n[1];
      end
      if (mode == 2) chk("R3 bit_count in conversion", bit_count, 0);
      @(negedge clk);
    end
    rd_start  = 1'b0;
    rd_strobe = 1'b0;
    rd_stop   = 1'b0;
  endtask

  initial begin
    int n;
    n_chk = 0; n_fail = 0; mon_en = 1'b0; finished = 1'b0;
    rst_n = 1'b0; supply_fault = 1'b0; rate_fast = 1'b0; sleep_req = 1'b0;
    sample_data = 16'hA5C3; rd_start = 1'b0; rd_strobe = 1'b0; rd_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk_reset("R1 reset");
    go();
    rst_n = 1'b1;
    measure(0, "R1", n);
    chk("R1 first conversion incl. sync", n, SLOW + 2);
    chk_idle("R4 nap no sleep", 1'b1);
    chk("R2 slow length seen", n - 2, SLOW);

    // R5: source changes after capture; R6: strobe and stop ignored in hold
    sample_data = 16'h0000;
    go(); rd_strobe = 1'b1;
    go(); rd_strobe = 1'b0; rd_stop = 1'b1;
    go(); rd_stop = 1'b0;
    @(negedge clk);
    chk("R6 hold ignores strobe/stop bit_count", bit_count, 0);
    chk("R6 hold ignores strobe/stop busy", busy, 0);

    // full read, fast conversion with mid-conversion rate flip
    go();
    rate_fast = 1'b1; sleep_req = 1'b1; sample_data = 16'h5A0F;
    read_bits(16'hA5C3, 16);
    measure(1, "R7", n);
    chk("R2 fast length, late flip deferred", n, FAST);
    chk_idle("R4 nap with sleep", 1'b0);

    // partial read then abort; slow conversion with read noise
    sleep_req = 1'b0; sample_data = 16'hFFFF;
    go();
    read_bits(16'h5A0F, 5);
    rd_stop = 1'b1;
    go();
    rd_stop = 1'b0;
    measure(2, "R8", n);
    chk("R3 conversion length under read noise", n, SLOW);
    chk_idle("R4 nap after abort", 1'b1);

    // full read of latest word, then fault in the middle of a read
    rate_fast = 1'b1; sample_data = 16'h8001;
    go();
    read_bits(16'hFFFF, 16);
    measure(0, "R7", n);
    chk("R2 fast length", n, FAST);
    go();
    read_bits(16'h8001, 7);
    supply_fault = 1'b1;
    @(negedge clk);
    chk_reset("R9 fault");
    go();
    supply_fault = 1'b0;
    measure(0, "R9", n);
    chk("R9 restart length incl. sync", n, FAST + 2);
    chk_idle("R9 nap after restart", 1'b1);
    go();
    read_bits(16'h8001, 16);
    @(negedge clk);
    chk("R7 busy after last bit", busy, 1);
    chk("R6 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule